// File: doc/BRIEF.md
# USART Fractional Clock and Baud Tick Generator

This block turns a fast main clock into the timing strobes that a USART channel needs. The path has three stages in a row. An integer prescaler divides the main clock. A fractional stage then drops input pulses through an 8-bit accumulator, so that the rate is divided by one plus MULT/256. A baud divider then counts the resulting peripheral enables. All outputs are single-cycle enables in the main clock domain. No derived clocks are produced.

The baud divider has two modes. In asynchronous mode it emits an oversample tick once every BRG peripheral enables, and a bit tick on every sixteenth oversample tick, which gives a bit rate of the peripheral rate divided by 16×BRG. In synchronous mode it emits a serial clock tick once every BRG peripheral enables, with no factor of 16. Software sets up the block through a small write-only register port. The prescaler and the baud divider pick up a new setting only when their counters reload, so a running tick stream never gets a short interval.

Top module: `usart_clkgen`

## Requirements
- R1: With MULT at 0, `pclk_en` pulses exactly once every CLKDIV main clock cycles when CLKDIV is nonzero.
- R2: While CLKDIV is 0, `pclk_en`, `os_tick`, `bit_tick` and `sclk_tick` stay low.
- R3: While the fractional select register holds 0xFF, any 256 consecutive `pclk_en` intervals together span exactly CLKDIV×(256+MULT) cycles, for any MULT from 0 to 255.
- R4: While the fractional select register holds any value other than 0xFF, MULT has no effect and `pclk_en` spacing is CLKDIV cycles.
- R5: With `sync_mode` low, `os_tick` pulses once every BRG `pclk_en` pulses, and `sclk_tick` stays low.
- R6: With `sync_mode` low, `bit_tick` pulses together with every sixteenth `os_tick`, so its spacing is 16×BRG peripheral enables.
- R7: With `sync_mode` high, `sclk_tick` pulses once every BRG `pclk_en` pulses, and `os_tick` and `bit_tick` stay low.
- R8: A BRG value of 0 behaves the same as a BRG value of 1.
- R9: A new CLKDIV or BRG value written in the middle of a count does not shorten the interval that is running. The running interval finishes at the old length, and the new length applies from the next interval.
- R10: On a write, byte offset 0x094 sets CLKDIV (data bits 7:0), 0x0F0 sets the fractional select register (bits 7:0), 0x0F4 sets MULT (bits 7:0), and 0x020 sets BRG (bits 15:0). Writes to any other offset change nothing.
- R11: During reset and just after it, all tick outputs are low. The reset values are CLKDIV=0, select=0, MULT=0 and BRG=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register byte offset |
| wr_data | input | 16 | Register write data |
| sync_mode | input | 1 | 1 selects synchronous serial clock ticks, 0 selects asynchronous oversample ticks |
| pclk_en | output | 1 | Peripheral clock enable after prescaler and fractional stage |
| os_tick | output | 1 | 16x oversample tick (asynchronous mode) |
| bit_tick | output | 1 | One-per-bit tick (asynchronous mode) |
| sclk_tick | output | 1 | Serial clock tick (synchronous mode) |

## Verification
The hardest condition to reach is the accumulator carry pattern. The fractional rate is only exact over a full 256-pulse window, and a skip lands on a different pulse for each MULT. The stimulus therefore draws random MULT, CLKDIV and BRG values from a fixed seed and measures spans of 256 oversample ticks against CLKDIV×BRG×(256+MULT). Small CLKDIV and BRG values keep each window short. Reload behaviour is reached by aligning a register write to the cycle after an observed pulse. That places the new value in the middle of a count, and the bench then checks that the next interval keeps the old length.

// File: rtl/usart_clkgen_pkg.sv
package usart_clkgen_pkg;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 16;
    localparam int PRE_W   = 8;
    localparam int FRAC_W  = 8;
    localparam int BRG_W   = 16;
    localparam int OS_RATE = 16;

    localparam logic [ADDR_W-1:0] OFS_BRG     = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_CLKDIV  = 12'h094;
    localparam logic [ADDR_W-1:0] OFS_FRACSEL = 12'h0F0;
    localparam logic [ADDR_W-1:0] OFS_MULT    = 12'h0F4;

    localparam logic [FRAC_W-1:0] FRAC_ON_CODE = '1;
endpackage

// File: rtl/usart_cfg_regs.sv
module usart_cfg_regs
    import usart_clkgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [PRE_W-1:0]  clkdiv_o,
    output logic [FRAC_W-1:0] fracsel_o,
    output logic [FRAC_W-1:0] mult_o,
    output logic [BRG_W-1:0]  brg_o
);
    typedef struct packed {
        logic [PRE_W-1:0]  clkdiv;
        logic [FRAC_W-1:0] fracsel;
        logic [FRAC_W-1:0] mult;
        logic [BRG_W-1:0]  brg;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            unique case (wr_addr)
                OFS_CLKDIV:  cfg_d.clkdiv  = wr_data[PRE_W-1:0];
                OFS_FRACSEL: cfg_d.fracsel = wr_data[FRAC_W-1:0];
                OFS_MULT:    cfg_d.mult    = wr_data[FRAC_W-1:0];
                OFS_BRG:     cfg_d.brg     = wr_data[BRG_W-1:0];
                default:     cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{clkdiv: '0, fracsel: '0, mult: '0, brg: BRG_W'(1)};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign clkdiv_o  = cfg_q.clkdiv;
    assign fracsel_o = cfg_q.fracsel;
    assign mult_o    = cfg_q.mult;
    assign brg_o     = cfg_q.brg;

    // R10: a write to an unmapped offset leaves every field unchanged
    a_r10_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != OFS_CLKDIV && wr_addr != OFS_FRACSEL &&
         wr_addr != OFS_MULT && wr_addr != OFS_BRG) |=> $stable(cfg_q));
endmodule

// File: rtl/usart_prescaler.sv
module usart_prescaler
    import usart_clkgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] clkdiv,
    output logic             pulse_o
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
        logic [PRE_W-1:0] lim;
    } pre_t;

    pre_t pre_d, pre_q;
    logic hit;

    always_comb begin
        pre_d = pre_q;
        hit   = (pre_q.lim != '0) && (pre_q.cnt == pre_q.lim - PRE_W'(1));
        if (pre_q.lim == '0) begin
            pre_d.cnt = '0;
            pre_d.lim = clkdiv;
        end else if (hit) begin
            pre_d.cnt = '0;
            pre_d.lim = clkdiv;
        end else begin
            pre_d.cnt = pre_q.cnt + PRE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign pulse_o = hit;

    // R1: the count never runs past the active limit
    a_r1_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_q.lim != '0) |-> (pre_q.cnt < pre_q.lim));
    // R9: the limit only changes on the cycle after a reload or while idle
    a_r9_limit_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_q.cnt != '0) |-> $stable(pre_q.lim));
endmodule

// File: rtl/usart_frac_gen.sv
module usart_frac_gen
    import usart_clkgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_pulse,
    input  logic [FRAC_W-1:0] fracsel,
    input  logic [FRAC_W-1:0] mult,
    output logic              out_pulse
);
    typedef struct packed {
        logic [FRAC_W-1:0] acc;
        logic              skip;
        logic              out;
    } frac_t;

    frac_t fr_d, fr_q;
    logic  frac_on;
    logic [FRAC_W:0] sum;

    always_comb begin
        fr_d    = fr_q;
        frac_on = (fracsel == FRAC_ON_CODE);
        sum     = {1'b0, fr_q.acc} + {1'b0, mult};
        fr_d.out = 1'b0;
        if (!frac_on) begin
            fr_d.skip = 1'b0;
            fr_d.out  = in_pulse;
        end else if (in_pulse) begin
            if (fr_q.skip) begin
                fr_d.skip = 1'b0;
            end else begin
                fr_d.out  = 1'b1;
                fr_d.acc  = sum[FRAC_W-1:0];
                fr_d.skip = sum[FRAC_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign out_pulse = fr_q.out;

    // R3: an output enable only follows an input pulse
    a_r3_out_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.out |-> $past(in_pulse));
    // R3: a pending skip swallows the next input pulse
    a_r3_skip_swallows: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.skip && in_pulse && frac_on) |=> !fr_q.out);
endmodule

// File: rtl/usart_baud_div.sv
module usart_baud_div
    import usart_clkgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pclk_en,
    input  logic [BRG_W-1:0] brg,
    input  logic             sync_mode,
    output logic             os_tick_o,
    output logic             bit_tick_o,
    output logic             sclk_tick_o
);
    localparam int OS_W = $clog2(OS_RATE);

    typedef struct packed {
        logic [BRG_W-1:0] cnt;
        logic [BRG_W-1:0] lim;
        logic [OS_W-1:0]  oscnt;
        logic             os;
        logic             bt;
        logic             sclk;
    } baud_t;

    baud_t bd_d, bd_q;
    logic  tick;
    logic [BRG_W-1:0] brg_eff;

    always_comb begin
        bd_d    = bd_q;
        brg_eff = (brg == '0) ? BRG_W'(1) : brg;
        tick    = pclk_en && (bd_q.cnt == bd_q.lim - BRG_W'(1));
        if (pclk_en) begin
            if (tick) begin
                bd_d.cnt = '0;
                bd_d.lim = brg_eff;
            end else begin
                bd_d.cnt = bd_q.cnt + BRG_W'(1);
            end
        end
        bd_d.os   = tick && !sync_mode;
        bd_d.sclk = tick && sync_mode;
        bd_d.bt   = tick && !sync_mode && (bd_q.oscnt == OS_W'(OS_RATE - 1));
        if (sync_mode)  bd_d.oscnt = '0;
        else if (tick)  bd_d.oscnt = bd_q.oscnt + OS_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bd_q <= '{cnt: '0, lim: BRG_W'(1), oscnt: '0, os: 1'b0, bt: 1'b0, sclk: 1'b0};
        else        bd_q <= bd_d;
    end

    assign os_tick_o   = bd_q.os;
    assign bit_tick_o  = bd_q.bt;
    assign sclk_tick_o = bd_q.sclk;

    // R8: the active limit is never zero
    a_r8_limit_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        bd_q.lim != '0);
    // R5: the count stays below the active limit
    a_r5_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        bd_q.cnt < bd_q.lim);
    // R6: a bit tick always coincides with an oversample tick
    a_r6_bit_on_os: assert property (@(posedge clk) disable iff (!rst_n)
        bd_q.bt |-> bd_q.os);
    // R7: serial clock ticks only follow a cycle in synchronous mode
    a_r7_sclk_mode: assert property (@(posedge clk) disable iff (!rst_n)
        bd_q.sclk |-> $past(sync_mode));
    // R5: oversample ticks only follow a peripheral enable
    a_r5_os_needs_pclk: assert property (@(posedge clk) disable iff (!rst_n)
        bd_q.os |-> $past(pclk_en));
endmodule

// File: rtl/usart_clkgen.sv
module usart_clkgen
    import usart_clkgen_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [11:0] wr_addr,
    input  logic [15:0] wr_data,
    input  logic        sync_mode,
    output logic        pclk_en,
    output logic        os_tick,
    output logic        bit_tick,
    output logic        sclk_tick
);
    logic [PRE_W-1:0]  clkdiv;
    logic [FRAC_W-1:0] fracsel;
    logic [FRAC_W-1:0] mult;
    logic [BRG_W-1:0]  brg;
    logic              pre_pulse;

    usart_cfg_regs u_regs (
        .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
        .clkdiv_o(clkdiv), .fracsel_o(fracsel), .mult_o(mult), .brg_o(brg)
    );

    usart_prescaler u_pre (
        .clk, .rst_n, .clkdiv(clkdiv), .pulse_o(pre_pulse)
    );

    usart_frac_gen u_frac (
        .clk, .rst_n, .in_pulse(pre_pulse), .fracsel(fracsel), .mult(mult),
        .out_pulse(pclk_en)
    );

    usart_baud_div u_baud (
        .clk, .rst_n, .pclk_en(pclk_en), .brg(brg), .sync_mode(sync_mode),
        .os_tick_o(os_tick), .bit_tick_o(bit_tick), .sclk_tick_o(sclk_tick)
    );

    // R2: with the divider at zero for two cycles running and no pulse pending, no enable follows
    a_r2_zero_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (clkdiv == '0 && $past(clkdiv) == '0 && !pre_pulse && !$past(pre_pulse)) |=> !pclk_en);
    // R7: the two mode outputs never fire together
    a_r7_modes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(os_tick && sclk_tick));
endmodule

// File: tb/test_usart_clkgen.sv
module test_usart_clkgen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        sync_mode = 1'b0;
    logic        pclk_en, os_tick, bit_tick, sclk_tick;

    int checks = 0;
    int errors = 0;
    longint cyc = 0;

    usart_clkgen i_usart_clkgen (
        .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .sync_mode,
        .pclk_en, .os_tick, .bit_tick, .sclk_tick
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        repeat (190000) @(posedge clk);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog: actual=expired expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    function automatic longint exp_span(int cdiv, int mult, int brg, int n);
        int b;
        b = (brg == 0) ? 1 : brg;
        return longint'(cdiv) * b * (n + mult * n / 256);
    endfunction

    task automatic check(string req, longint act, longint exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic sel_sig(int sel);
        case (sel)
            0: return pclk_en;
            1: return os_tick;
            2: return bit_tick;
            default: return sclk_tick;
        endcase
    endfunction

    task automatic wr(logic [11:0] a, logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_pulse(int sel, output longint t);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sel_sig(sel) && n < 60000);
        t = cyc;
    endtask

    task automatic span(int sel, int n, output longint d);
        longint t0, t1;
        wait_pulse(sel, t0);
        for (int i = 0; i < n; i++) wait_pulse(sel, t1);
        d = t1 - t0;
    endtask

    task automatic count_quiet(int sel, int ncyc, output int hits);
        hits = 0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (sel_sig(sel)) hits++;
        end
    endtask

    initial begin
        longint d, t;
        int h, cd, ml, bg;
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        // R11: outputs low in reset
        check("R11 reset pclk", pclk_en, 0);
        check("R11 reset os", os_tick | bit_tick | sclk_tick, 0);
        rst_n = 1'b1;
        // R11/R2: reset CLKDIV is 0, nothing runs
        count_quiet(0, 60, h);
        check("R11 no pclk after reset", h, 0);

        // R1: plain prescaler, MULT 0
        wr(12'h094, 16'd5);
        span(0, 4, d);
        check("R1 clkdiv 5", d, 20);
        // R10: unmapped offset ignored
        wr(12'h098, 16'd2);
        wr(12'h093, 16'd2);
        span(0, 2, d); span(0, 4, d);
        check("R10 unmapped write", d, 20);

        // R4: MULT ignored while select != 0xFF
        wr(12'h0F4, 16'd200);
        span(0, 2, d); span(0, 8, d);
        check("R4 mult ignored", d, 40);

        // R3: fractional on
        wr(12'h094, 16'd2);
        wr(12'h0F0, 16'h00FF);
        wr(12'h0F4, 16'd0);
        span(0, 3, d); span(0, 256, d);
        check("R3 mult 0 passthrough", d, 512);
        wr(12'h0F4, 16'd128);
        span(0, 3, d); span(0, 256, d);
        check("R3 mult 128", d, exp_span(2, 128, 1, 256));
        wr(12'h0F4, 16'd255);
        span(0, 3, d); span(0, 256, d);
        check("R3 mult 255", d, exp_span(2, 255, 1, 256));

        // R5: async oversample tick
        wr(12'h0F0, 16'h0000);
        wr(12'h094, 16'd3);
        wr(12'h020, 16'd4);
        span(1, 2, d); span(1, 5, d);
        check("R5 os spacing", d, exp_span(3, 0, 4, 5));
        count_quiet(3, 200, h);
        check("R5 sclk quiet in async", h, 0);
        // R6: bit tick
        span(2, 1, d); span(2, 2, d);
        check("R6 bit spacing", d, exp_span(3, 0, 4, 32));

        // R7: sync mode
        sync_mode = 1'b1;
        span(3, 2, d); span(3, 5, d);
        check("R7 sclk spacing", d, exp_span(3, 0, 4, 5));
        count_quiet(1, 200, h);
        check("R7 os quiet in sync", h, 0);
        count_quiet(2, 200, h);
        check("R7 bit quiet in sync", h, 0);
        sync_mode = 1'b0;

        // R8: BRG 0 as 1
        wr(12'h020, 16'd0);
        span(1, 3, d); span(1, 6, d);
        check("R8 brg zero", d, 18);

        // R9: BRG change mid-count
        wr(12'h094, 16'd1);
        wr(12'h020, 16'd10);
        span(1, 3, d);
        wait_pulse(1, t);
        repeat (3) @(negedge clk);
        wr(12'h020, 16'd3);
        span(1, 0, d);
        d = cyc - t;
        check("R9 brg old interval kept", d, 10);
        span(1, 1, d);
        check("R9 brg new interval", d, 3);

        // R9: CLKDIV change mid-count
        wr(12'h020, 16'd1);
        wr(12'h094, 16'd8);
        span(0, 3, d);
        wait_pulse(0, t);
        wr(12'h094, 16'd2);
        wait_pulse(0, d);
        check("R9 clkdiv old interval kept", d - t, 8);
        span(0, 1, d);
        check("R9 clkdiv new interval", d, 2);

        // R3/R5 random configurations
        wr(12'h0F0, 16'h00FF);
        for (int k = 0; k < 4; k++) begin
            cd = 1 + int'($urandom_range(2, 0));
            ml = int'($urandom_range(255, 0));
            bg = 1 + int'($urandom_range(3, 0));
            wr(12'h094, 16'(cd));
            wr(12'h0F4, 16'(ml));
            wr(12'h020, 16'(bg));
            span(1, 3, d); span(1, 256, d);
            check("R3 R5 random span", d, exp_span(cd, ml, bg, 256));
        end

        // R2: CLKDIV 0 stops everything
        wr(12'h094, 16'd0);
        repeat (20) @(negedge clk);
        count_quiet(0, 300, h);
        check("R2 pclk stopped", h, 0);
        count_quiet(1, 100, h);
        check("R2 os stopped", h, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule